// File: doc/BRIEF.md
# Write-Triggered DMA Channel Front End

This block is the register-mapped front end for a set of fast DMA channels (eight by default). Each channel carries a map entry that names one parameter slot and one word inside that slot. When a bus write lands on that exact word and the channel is enabled, the block latches an event for the channel. It then offers a transfer request to the transfer engine, carrying the channel number and the slot number. Software starts a transfer by writing the chosen word of a parameter slot. It does not write a start bit.

Each channel has an enable bit. Software changes the enables only through a write-ones-to-set register and a write-ones-to-clear register. A per-channel event flag stays set from the trigger until the engine takes the request. A trigger that arrives while the flag is still set is recorded as a missed event, and no second request is raised. The engine reports each finished transfer with a completion code. If interrupts are enabled for that transfer, the code sets one bit of a 64-bit pending vector. Software clears pending bits by writing ones. The parameter storage and the engine itself sit outside this block.

Top module: `wtrig_dma_front`

## Requirements
- R1: Each channel c has a map register at byte address 0x200 + 4·c, and all map registers reset to zero. A write keeps bits 13:5 as the slot number and bits 4:2 as the word index. A read returns those two fields in the same positions and zero in every other bit.
- R2: Writing to 0x108C sets the enable of channel i for every bit i that is 1. Writing to 0x1088 clears the enable of channel i for every bit i that is 1. A 0 bit in either write leaves its channel unchanged. A read of either address returns the enable vector in bits 7:0.
- R3: A write to byte address 0x4000 + 32·slot + 4·word triggers every channel whose map holds that slot and word, provided the channel is enabled and its map value is nonzero. A map value of zero means the channel is detached. After the triggering clock edge, req_valid is high and the channel's event flag reads as 1 at 0x1094.
- R4: While any event flag is set, req_valid is high. req_chan then names the lowest-numbered channel with its flag set, and req_slot gives that channel's mapped slot. When req_ready is high with req_valid, that channel's flag clears at the same edge.
- R5: A trigger for a channel whose event flag is set, and is not being cleared in the same cycle, sets that channel's missed bit and raises no extra request. The missed bits read at 0x314. Writing ones there clears them, and zero bits have no effect.
- R6: Writing ones to 0x1094 clears the matching event flags and withdraws their requests.
- R7: When cmpl_valid and cmpl_int_en are both high, pending bit cmpl_code is set. When cmpl_int_en is low, the pending bits are left unchanged. Codes 0–31 read at 0x1068 and codes 32–63 read at 0x106C, with bit k mod 32 holding code k.
- R8: Writing ones to 0x1070 clears pending codes 0–31, and writing ones to 0x1074 clears codes 32–63. If a completion sets a bit in the same cycle that a write clears it, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one bus cycle |
| bus_addr | input | 16 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cmpl_valid | input | 1 | Completion report from the engine |
| cmpl_code | input | 6 | Completion code of the report |
| cmpl_int_en | input | 1 | Completion interrupts enabled for that transfer |
| req_valid | output | 1 | Transfer request is being offered |
| req_ready | input | 1 | Engine takes the request this cycle |
| req_chan | output | 3 | Channel of the offered request |
| req_slot | output | 9 | Parameter slot of the offered request |

## Verification
Almost every piece of state shows at the ports one edge after the stimulus that changes it. A corrupted map entry shows up on the very next write to a slot word: a trigger goes missing, or one appears at the wrong word. A corrupted event flag appears right away on req_valid or req_chan, and a wrong missed decision shows when the second request fails to disappear after one acceptance. A bad pending bit can sit unseen until the next read of its pending word. For that reason every injected code is read back the following cycle, and then read back again after its clear.

// File: rtl/wtrig_pkg.sv
package wtrig_pkg;
   // Read-path source selected by the address decoder.
   typedef enum logic [2:0] {
      RD_NONE,
      RD_MAP,
      RD_ENABLE,
      RD_SECOND,
      RD_MISSED,
      RD_PEND
   } rd_sel_e;
endpackage

// File: rtl/wtrig_map.sv
// Per-channel map registers and trigger-word address comparators.
module wtrig_map #(
   parameter int NUM_CH    = 8,
   parameter int SLOT_W    = 9,
   parameter int WORD_W    = 3,
   parameter int ADDR_W    = 16,
   parameter int MAP_BASE  = 'h200,
   parameter int SLOT_BASE = 'h4000,
   localparam int MAP_W    = SLOT_W + WORD_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [MAP_W-1:0]              wfield,
   output logic [NUM_CH-1:0][MAP_W-1:0]  map_q,
   output logic [NUM_CH-1:0]             hit
);
   localparam int SH         = WORD_W + 2;
   localparam int REGION_END = SLOT_BASE + (1 << (SLOT_W + SH));

   if (SH + SLOT_W > ADDR_W) begin : g_bad_addr
      $error("slot region does not fit the address width");
   end
   if (REGION_END > (1 << ADDR_W)) begin : g_bad_region
      $error("slot region runs past the address space");
   end

   logic [ADDR_W-1:0] offs;
   logic              in_region;

   assign offs      = addr - ADDR_W'(SLOT_BASE);
   assign in_region = ({1'b0, addr} >= (ADDR_W+1)'(SLOT_BASE)) &&
                      ({1'b0, addr} <  (ADDR_W+1)'(REGION_END));

   wire unused_offs = ^{offs[1:0], offs[ADDR_W-1:SH+SLOT_W]};

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n)
            map_q[c] <= '0;
         else if (wr && addr == ADDR_W'(MAP_BASE + 4*c))
            map_q[c] <= wfield;
      end

      assign hit[c] = wr && in_region && (|map_q[c]) &&
                      (offs[SH +: SLOT_W] == map_q[c][WORD_W +: SLOT_W]) &&
                      (offs[2 +: WORD_W]  == map_q[c][WORD_W-1:0]);
   end
endmodule

// File: rtl/wtrig_events.sv
// Enables, event flags, missed-event detection and request selection.
module wtrig_events #(
   parameter int NUM_CH = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] hit,
   input  logic [NUM_CH-1:0] en_set,
   input  logic [NUM_CH-1:0] en_clr,
   input  logic [NUM_CH-1:0] sec_clr,
   input  logic [NUM_CH-1:0] miss_clr,
   input  logic              req_ready,
   output logic [NUM_CH-1:0] en_q,
   output logic [NUM_CH-1:0] sec_q,
   output logic [NUM_CH-1:0] miss_q,
   output logic              req_valid,
   output logic [CH_W-1:0]   req_chan
);
   logic [NUM_CH-1:0] trig, acc, busy;

   // Lowest-numbered flagged channel is offered first.
   always_comb begin
      req_chan = '0;
      for (int i = NUM_CH - 1; i >= 0; i--)
         if (sec_q[i]) req_chan = CH_W'(i);
   end

   assign req_valid = |sec_q;
   assign acc       = (req_valid && req_ready) ? (NUM_CH'(1) << req_chan) : '0;
   assign trig      = hit & en_q;
   // Flag that survives this edge: a trigger on it is lost.
   assign busy      = sec_q & ~acc & ~sec_clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         sec_q  <= '0;
         miss_q <= '0;
      end else begin
         en_q   <= (en_q | en_set) & ~en_clr;
         sec_q  <= busy | trig;
         miss_q <= (miss_q & ~miss_clr) | (trig & busy);
      end
   end
endmodule

// File: rtl/wtrig_pending.sv
// Completion-pending vector with per-word write-one-to-clear; set wins.
module wtrig_pending #(
   parameter int CODE_W   = 6,
   parameter int DATA_W   = 32,
   localparam int NBITS   = 1 << CODE_W,
   localparam int NWORDS  = NBITS / DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_valid,
   input  logic [CODE_W-1:0] set_code,
   input  logic [NWORDS-1:0] clr_we,
   input  logic [DATA_W-1:0] clr_data,
   output logic [NBITS-1:0]  pend_q
);
   if (NBITS % DATA_W != 0 || NWORDS < 1) begin : g_bad_split
      $error("pending vector must split into whole data words");
   end

   logic [NBITS-1:0] set_mask, clr_mask;

   assign set_mask = set_valid ? (NBITS'(1) << set_code) : '0;

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      assign clr_mask[w*DATA_W +: DATA_W] = clr_we[w] ? clr_data : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= '0;
      else
         pend_q <= (pend_q & ~clr_mask) | set_mask;
   end
endmodule

// File: rtl/wtrig_dma_front.sv
// Write-triggered DMA channel front end: decode, read path and glue.
module wtrig_dma_front
   import wtrig_pkg::*;
#(
   parameter int NUM_CH        = 8,
   parameter int SLOT_W        = 9,
   parameter int WORD_W        = 3,
   parameter int CODE_W        = 6,
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 32,
   parameter int MAP_BASE      = 'h200,
   parameter int SLOT_BASE     = 'h4000,
   parameter int EN_SET_ADDR   = 'h108C,
   parameter int EN_CLR_ADDR   = 'h1088,
   parameter int SEC_CLR_ADDR  = 'h1094,
   parameter int MISS_CLR_ADDR = 'h314,
   parameter int PEND_ADDR     = 'h1068,
   parameter int PEND_CLR_ADDR = 'h1070,
   localparam int CH_W         = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cmpl_valid,
   input  logic [CODE_W-1:0] cmpl_code,
   input  logic              cmpl_int_en,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [CH_W-1:0]   req_chan,
   output logic [SLOT_W-1:0] req_slot
);
   localparam int MAP_W      = SLOT_W + WORD_W;
   localparam int PEND_BITS  = 1 << CODE_W;
   localparam int PEND_WORDS = PEND_BITS / DATA_W;
   localparam int PW_W       = (PEND_WORDS > 1) ? $clog2(PEND_WORDS) : 1;
   localparam int IDX_W      = (CH_W > PW_W) ? CH_W : PW_W;

   if (NUM_CH < 2 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("channel count must lie between 2 and the data width");
   end
   if (MAP_W + 2 > DATA_W) begin : g_bad_map
      $error("map fields do not fit a data word");
   end

   logic [NUM_CH-1:0][MAP_W-1:0]      map_field;
   logic [NUM_CH-1:0]                 hit, en_q, sec_q, miss_q;
   logic [NUM_CH-1:0]                 en_set_v, en_clr_v, sec_clr_v, miss_clr_v;
   logic [PEND_BITS-1:0]              pend_q;
   logic [PEND_WORDS-1:0][DATA_W-1:0] pend_words;
   logic [PEND_WORDS-1:0]             pclr_we;
   rd_sel_e                           rsel;
   logic [IDX_W-1:0]                  ridx;

   function automatic logic at(input int a);
      return bus_addr == ADDR_W'(a);
   endfunction

   // Write decode for the set/clear registers.
   assign en_set_v   = (bus_wr && at(EN_SET_ADDR))   ? bus_wdata[NUM_CH-1:0] : '0;
   assign en_clr_v   = (bus_wr && at(EN_CLR_ADDR))   ? bus_wdata[NUM_CH-1:0] : '0;
   assign sec_clr_v  = (bus_wr && at(SEC_CLR_ADDR))  ? bus_wdata[NUM_CH-1:0] : '0;
   assign miss_clr_v = (bus_wr && at(MISS_CLR_ADDR)) ? bus_wdata[NUM_CH-1:0] : '0;

   for (genvar w = 0; w < PEND_WORDS; w++) begin : g_pclr
      assign pclr_we[w] = bus_wr && at(PEND_CLR_ADDR + 4*w);
   end

   wtrig_map #(
      .NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
      .MAP_BASE(MAP_BASE), .SLOT_BASE(SLOT_BASE)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wfield(bus_wdata[MAP_W+1:2]), .map_q(map_field), .hit(hit)
   );

   wtrig_events #(.NUM_CH(NUM_CH)) u_events (
      .clk(clk), .rst_n(rst_n), .hit(hit),
      .en_set(en_set_v), .en_clr(en_clr_v),
      .sec_clr(sec_clr_v), .miss_clr(miss_clr_v),
      .req_ready(req_ready), .en_q(en_q), .sec_q(sec_q), .miss_q(miss_q),
      .req_valid(req_valid), .req_chan(req_chan)
   );

   wtrig_pending #(.CODE_W(CODE_W), .DATA_W(DATA_W)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .set_valid(cmpl_valid && cmpl_int_en), .set_code(cmpl_code),
      .clr_we(pclr_we), .clr_data(bus_wdata), .pend_q(pend_q)
   );

   assign req_slot   = map_field[req_chan][WORD_W +: SLOT_W];
   assign pend_words = pend_q;

   // Read decode.
   always_comb begin
      rsel = RD_NONE;
      ridx = '0;
      for (int c = 0; c < NUM_CH; c++)
         if (at(MAP_BASE + 4*c)) begin
            rsel = RD_MAP;
            ridx = IDX_W'(c);
         end
      if (at(EN_SET_ADDR) || at(EN_CLR_ADDR)) rsel = RD_ENABLE;
      if (at(SEC_CLR_ADDR))                   rsel = RD_SECOND;
      if (at(MISS_CLR_ADDR))                  rsel = RD_MISSED;
      for (int w = 0; w < PEND_WORDS; w++)
         if (at(PEND_ADDR + 4*w)) begin
            rsel = RD_PEND;
            ridx = IDX_W'(w);
         end
   end

   // Read mux.
   always_comb begin
      case (rsel)
         RD_MAP:    bus_rdata = DATA_W'({map_field[ridx[CH_W-1:0]], 2'b00});
         RD_ENABLE: bus_rdata = DATA_W'(en_q);
         RD_SECOND: bus_rdata = DATA_W'(sec_q);
         RD_MISSED: bus_rdata = DATA_W'(miss_q);
         RD_PEND:   bus_rdata = pend_words[ridx[PW_W-1:0]];
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wtrig_checker.sv
// Temporal properties of the write-triggered front end.
module wtrig_checker #(
   parameter int NUM_CH  = 8,
   parameter int CODE_W  = 6,
   parameter int PWORDS  = 2,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int NBITS  = 1 << CODE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] sec,
   input logic [NUM_CH-1:0] miss,
   input logic [NUM_CH-1:0] en,
   input logic [NUM_CH-1:0] en_set,
   input logic [NUM_CH-1:0] en_clr,
   input logic              req_valid,
   input logic [CH_W-1:0]   req_chan,
   input logic              cmpl_valid,
   input logic              cmpl_int_en,
   input logic [CODE_W-1:0] cmpl_code,
   input logic [NBITS-1:0]  pend,
   input logic [PWORDS-1:0] pclr_we
);
   AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|en_set) |=> ((en & $past(en_set)) == $past(en_set))); // R2
   AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (|en_clr) |=> ((en & $past(en_clr)) == '0)); // R2
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (sec == '0) |-> !req_valid); // R4
   AST_REQ_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (sec[req_chan] &&
                     ((sec & ((NUM_CH'(1) << req_chan) - NUM_CH'(1))) == '0))); // R4
   AST_MISS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ((miss & ~$past(miss) & ~$past(sec)) == '0)); // R5
   AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl_valid && cmpl_int_en) |=> pend[$past(cmpl_code)]); // R7
   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cmpl_valid && cmpl_int_en) && pclr_we == '0) |=> $stable(pend)); // R8
endmodule

bind wtrig_dma_front wtrig_checker #(
   .NUM_CH(NUM_CH), .CODE_W(CODE_W), .PWORDS(PEND_WORDS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sec(sec_q), .miss(miss_q), .en(en_q),
   .en_set(en_set_v), .en_clr(en_clr_v), .req_valid(req_valid),
   .req_chan(req_chan), .cmpl_valid(cmpl_valid), .cmpl_int_en(cmpl_int_en),
   .cmpl_code(cmpl_code), .pend(pend_q), .pclr_we(pclr_we)
);

// File: tb/wtrig_dma_front_test.sv
module wtrig_dma_front_test;
   localparam logic [15:0] A_MAP   = 16'h0200;
   localparam logic [15:0] A_ESET  = 16'h108C;
   localparam logic [15:0] A_ECLR  = 16'h1088;
   localparam logic [15:0] A_SEC   = 16'h1094;
   localparam logic [15:0] A_MISS  = 16'h0314;
   localparam logic [15:0] A_PEND  = 16'h1068;
   localparam logic [15:0] A_PCLR  = 16'h1070;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cmpl_valid = 1'b0;
   logic [5:0]  cmpl_code = '0;
   logic        cmpl_int_en = 1'b0;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [2:0]  req_chan;
   logic [8:0]  req_slot;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   wtrig_dma_front uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmpl_valid(cmpl_valid),
      .cmpl_code(cmpl_code), .cmpl_int_en(cmpl_int_en), .req_valid(req_valid),
      .req_ready(req_ready), .req_chan(req_chan), .req_slot(req_slot)
   );

   function automatic int slot_of(input int c);
      return c * 37 + 5;
   endfunction
   function automatic int word_of(input int c);
      return (c * 3 + 1) % 8;
   endfunction
   function automatic logic [15:0] taddr(input int s, input int w);
      return 16'(32'h4000 + s * 32 + w * 4);
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic take();
      @(negedge clk); req_ready = 1'b1;
      @(negedge clk); req_ready = 1'b0;
   endtask

   task automatic complete(input int k, input logic ie);
      @(negedge clk);
      cmpl_valid = 1'b1; cmpl_code = 6'(k); cmpl_int_en = ie;
      @(negedge clk);
      cmpl_valid = 1'b0; cmpl_int_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Reset state
      rd(A_MAP, d);          chk("R1 map reset", d, 0);
      rd(A_ESET, d);         chk("R2 enable reset", d, 0);
      rd(A_PEND, d);         chk("R7 pending reset", d, 0);
      chk("R4 no request at reset", req_valid, 0);

      // R1: map fields kept, other bits dropped
      for (int c = 0; c < 8; c++) begin
         wr(16'(A_MAP + 4*c), 32'hFFFFC003 | 32'(slot_of(c) << 5) | 32'(word_of(c) << 2));
         rd(16'(A_MAP + 4*c), d);
         chk("R1 map readback", d, 64'(slot_of(c) << 5 | word_of(c) << 2));
      end

      // R3: disabled channel ignores its trigger word
      wr(taddr(slot_of(0), word_of(0)), 32'h1);
      chk("R3 disabled no request", req_valid, 0);
      rd(A_SEC, d); chk("R3 disabled no flag", d, 0);

      // R2: set/clear enables
      wr(A_ESET, 32'hFFFFFF55); rd(A_ESET, d); chk("R2 set", d, 32'h55);
      wr(A_ECLR, 32'h05);       rd(A_ECLR, d); chk("R2 clear", d, 32'h50);
      wr(A_ESET, 32'hAA);       rd(A_ESET, d); chk("R2 set more", d, 32'hFA);
      wr(A_ECLR, 32'h00);       rd(A_ECLR, d); chk("R2 zero clear", d, 32'hFA);
      wr(A_ESET, 32'hFF);       rd(A_ESET, d); chk("R2 all on", d, 32'hFF);

      // R3/R4: sweep every word of every mapped slot
      for (int c = 0; c < 8; c++) begin
         for (int t = 0; t < 8; t++) begin
            wr(taddr(slot_of(c), t), 32'hA5A5_0000 | 32'(t));
            if (t == word_of(c)) begin
               chk("R3 trigger valid", req_valid, 1);
               chk("R4 trigger chan", req_chan, 64'(c));
               chk("R4 trigger slot", req_slot, 64'(slot_of(c)));
               rd(A_SEC, d); chk("R3 flag set", d, 64'(1 << c));
               take();
               chk("R4 accept drops request", req_valid, 0);
               rd(A_SEC, d); chk("R4 accept clears flag", d, 0);
            end else begin
               chk("R3 other word no request", req_valid, 0);
            end
         end
      end

      // R3: detached channel
      wr(16'(A_MAP + 12), 32'h0);
      wr(16'h4000, 32'h1);
      chk("R3 detached slot0 word0", req_valid, 0);
      wr(taddr(slot_of(3), word_of(3)), 32'h1);
      chk("R3 detached old word", req_valid, 0);
      wr(16'(A_MAP + 12), 32'(slot_of(3) << 5 | word_of(3) << 2));

      // R3: enable cleared
      wr(A_ECLR, 32'h02);
      wr(taddr(slot_of(1), word_of(1)), 32'h1);
      chk("R3 cleared enable", req_valid, 0);
      wr(A_ESET, 32'h02);

      // R4: lowest channel first
      wr(taddr(slot_of(6), word_of(6)), 32'h1);
      wr(taddr(slot_of(2), word_of(2)), 32'h1);
      chk("R4 order first chan", req_chan, 2);
      chk("R4 order first slot", req_slot, 64'(slot_of(2)));
      take();
      chk("R4 order second valid", req_valid, 1);
      chk("R4 order second chan", req_chan, 6);
      take();
      chk("R4 order drained", req_valid, 0);

      // R5: missed event
      wr(taddr(slot_of(4), word_of(4)), 32'h1);
      wr(taddr(slot_of(4), word_of(4)), 32'h2);
      rd(A_MISS, d); chk("R5 missed set", d, 32'h10);
      rd(A_SEC, d);  chk("R5 flag still one", d, 32'h10);
      chk("R5 request chan", req_chan, 4);
      take();
      chk("R5 single request", req_valid, 0);
      wr(A_MISS, 32'h0);  rd(A_MISS, d); chk("R5 zero clear", d, 32'h10);
      wr(A_MISS, 32'h10); rd(A_MISS, d); chk("R5 cleared", d, 0);

      // R6: software clear of event flag
      wr(taddr(slot_of(5), word_of(5)), 32'h1);
      chk("R6 pre valid", req_valid, 1);
      wr(A_SEC, 32'h20);
      chk("R6 withdrawn", req_valid, 0);
      rd(A_SEC, d); chk("R6 flag cleared", d, 0);

      // R7/R8: every completion code
      for (int k = 0; k < 64; k++) begin
         logic [31:0] lo, hi;
         complete(k, 1'b1);
         rd(A_PEND, lo); rd(16'(A_PEND + 4), hi);
         chk("R7 pending low", lo, (k < 32) ? 64'(32'(1) << k) : 0);
         chk("R7 pending high", hi, (k >= 32) ? 64'(32'(1) << (k - 32)) : 0);
         wr(16'(A_PCLR + 4*(k / 32)), 32'(1) << (k % 32));
         rd(16'(A_PEND + 4*(k / 32)), lo);
         chk("R8 cleared", lo, 0);
      end

      // R7: interrupt disable ignores completion
      complete(0, 1'b0); complete(33, 1'b0); complete(63, 1'b0);
      rd(A_PEND, d); chk("R7 ignored low", d, 0);
      rd(16'(A_PEND + 4), d); chk("R7 ignored high", d, 0);

      // R8: set wins over same-cycle clear
      complete(0, 1'b1); complete(3, 1'b1);
      @(negedge clk);
      cmpl_valid = 1'b1; cmpl_code = 6'd3; cmpl_int_en = 1'b1;
      bus_wr = 1'b1; bus_addr = A_PCLR; bus_wdata = 32'h9;
      @(negedge clk);
      cmpl_valid = 1'b0; cmpl_int_en = 1'b0; bus_wr = 1'b0;
      rd(A_PEND, d); chk("R8 set wins", d, 32'h8);
      wr(16'(A_PCLR + 4), 32'hFFFFFFFF);
      rd(A_PEND, d); chk("R8 high clear leaves low", d, 32'h8);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule